// File: doc/BRIEF.md
# Spare Line Remapper for a Four-Quadrant Memory Array

This block is the address-side redundancy logic of a memory array split into four quadrants, each of 64 rows by 256 columns. Each quadrant owns two spare rows; quadrants 0 and 1 share one group of four spare columns, and quadrants 2 and 3 share a second group. A bank of one-way repair registers models blown fuses. For each spare, the bank holds an enable bit, a kill bit and the address that the spare replaces. On every access the block takes a quadrant number, a row address and a column address. From these it decides, in the same cycle and with no register in the path, whether the normal row and column lines may fire or which spare stands in for them.

A fault-free part needs no programming: an unprogrammed spare never fires. Once a main line has been claimed by an enabled entry, that line stays disconnected. A column repair also cuts the column from its data line pair. A spare that turns out to be bad is killed with its kill bit, and its address is encoded again in a spare with a higher index of the same group. Among matching live spares, the one with the highest index wins. A flag reports any address that more than one live spare matches.

Repair registers are written through a parallel programming port guarded by a two-state controller:
- `ST_LOCKED` is entered on power-on reset and whenever `prog_en` is low. In this state every write is ignored.
- `ST_OPEN` is entered on the clock edge after `prog_en` is seen high, and a write is accepted only in this state.

The controller has two transitions:
- arm: `ST_LOCKED` to `ST_OPEN` while `prog_en` is high.
- lock: `ST_OPEN` to `ST_LOCKED` when `prog_en` is low.

Top module: `spare_remap`

## Requirements
- R1: After power-on reset (`por_n` low) every repair register reads zero. Every access then gives `row_main_en`=1, `col_main_en`=1, `row_spare_sel`=0, `col_spare_sel`=0 and `multi_hit`=0.
- R2: A row entry fires when it is enabled and not killed and its low 6 address bits equal `acc_row`. Only the entries of quadrant `acc_quad` take part, and the row entry index is quadrant*2+spare. A firing entry sets bit `spare` of `row_spare_sel`.
- R3: A column entry fires when it is enabled and not killed and its 8 address bits equal `acc_col`. Only the entries of pair `acc_quad[1]` take part, and the column entry index is pair*4+spare. A firing entry sets bit `spare` of `col_spare_sel`. A column spare therefore serves both quadrants of its pair and neither quadrant of the other pair.
- R4: Any enabled entry of the group whose address matches, killed or not, drives the main line's enable (`row_main_en` or `col_main_en`) to 0. The main line stays off even when no live spare replaces it.
- R5: A killed entry never fires. When several live entries of one group match, only the one with the highest spare index is selected, so each select vector is zero or one-hot.
- R6: `multi_hit` is 1 exactly when more than one live entry matches, in the row group or in the column group.
- R7: A write (`prog_we`=1) is accepted only in `ST_OPEN`. This state is reached on the clock edge after `prog_en` is sampled high. A write made with `prog_en` low, or in the first cycle `prog_en` is high, has no effect.
- R8: A write ORs `prog_data` into the entry named by `prog_tgt` (0 = row bank, 1 = column bank) and `prog_idx`. The data fields are: bit 9 enable, bit 8 kill, bits 7:0 address. A bit that is set cannot be cleared except by `por_n`.
- R9: The outputs depend on the access inputs with no clock delay, so a spare resolves in the same cycle as a normal line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the programming port |
| por_n | input | 1 | Active-low power-on reset, asynchronous; clears all repair registers |
| acc_quad | input | 2 | Quadrant of the access |
| acc_row | input | 6 | Row address inside the quadrant |
| acc_col | input | 8 | Column address |
| prog_en | input | 1 | Programming window request |
| prog_we | input | 1 | Write strobe for one repair entry |
| prog_tgt | input | 1 | Bank select: 0 row, 1 column |
| prog_idx | input | 3 | Entry index inside the selected bank |
| prog_data | input | 10 | {enable, kill, address[7:0]}, ORed into the entry |
| row_main_en | output | 1 | Normal row line may fire |
| row_spare_sel | output | 2 | One-hot select of the quadrant's spare rows |
| col_main_en | output | 1 | Normal column line and its data line pair stay connected |
| col_spare_sel | output | 4 | One-hot select of the pair's spare columns |
| multi_hit | output | 1 | More than one live spare matches the address |

## Verification
The hardest case to reach is a chained repair: a spare that was killed after it was programmed, with its address encoded again in a later spare, while the main line must stay cut. The bench first programs a row spare, then blows that spare's kill bit in a separate write, and then encodes the same address in the other spare of the quadrant. It checks the outputs after each of these three steps. A second hard case is the programming window's first cycle. The bench raises the window request and the write strobe together and then confirms through a normal access that the entry is still blank.

// File: rtl/spr_pkg.sv
package spr_pkg;
    typedef enum logic {
        ST_LOCKED = 1'b0,
        ST_OPEN   = 1'b1
    } prog_state_t;

    localparam int FUSE_AW   = 8;
    localparam int FUSE_DW   = FUSE_AW + 2;
    localparam int BIT_EN    = FUSE_DW - 1;
    localparam int BIT_KILL  = FUSE_DW - 2;
endpackage

// File: rtl/spr_prog_ctrl.sv
module spr_prog_ctrl
    import spr_pkg::*;
(
    input  logic clk,
    input  logic por_n,
    input  logic prog_en,
    input  logic prog_we,
    input  logic prog_tgt,
    output logic wr_row,
    output logic wr_col
);
    prog_state_t state_q, state_d;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) state_q <= ST_LOCKED;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_LOCKED: if (prog_en)  state_d = ST_OPEN;
            ST_OPEN:   if (!prog_en) state_d = ST_LOCKED;
            default:   state_d = ST_LOCKED;
        endcase
    end

    always_comb begin
        wr_row = 1'b0;
        wr_col = 1'b0;
        unique case (state_q)
            ST_LOCKED: ;
            ST_OPEN: begin
                wr_row = prog_en && prog_we && !prog_tgt;
                wr_col = prog_en && prog_we &&  prog_tgt;
            end
            default: ;
        endcase
    end

    // R7: no write is accepted unless the window was requested a cycle earlier
    p_no_early_write_r7: assert property (@(posedge clk) disable iff (!por_n)
        !$past(prog_en) |-> !(wr_row || wr_col));
endmodule

// File: rtl/spr_fuse_bank.sv
module spr_fuse_bank #(
    parameter int N_ENT = 8,
    parameter int DW    = 10,
    localparam int IW   = $clog2(N_ENT)
) (
    input  logic                        clk,
    input  logic                        por_n,
    input  logic                        wr,
    input  logic [IW-1:0]               idx,
    input  logic [DW-1:0]               data,
    output logic [N_ENT-1:0][DW-1:0]    fuse_q
);
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            fuse_q <= '0;
        end else if (wr) begin
            fuse_q[idx] <= fuse_q[idx] | data;
        end
    end

    // R8: a blown bit never returns to zero while power is held
    p_fuse_one_way_r8: assert property (@(posedge clk) disable iff (!por_n)
        (($past(fuse_q) & ~fuse_q) == '0));
    // R7: the bank is untouched in any cycle without an accepted write
    p_hold_without_write_r7: assert property (@(posedge clk) disable iff (!por_n)
        !wr |=> $stable(fuse_q));
endmodule

// File: rtl/spr_match.sv
module spr_match #(
    parameter int N  = 2,
    parameter int AW = 6,
    localparam int CW = $clog2(N + 1)
) (
    input  logic                 clk,
    input  logic                 por_n,
    input  logic [N-1:0]         en,
    input  logic [N-1:0]         kill,
    input  logic [N-1:0][AW-1:0] addr,
    input  logic [AW-1:0]        key,
    output logic                 main_en,
    output logic [N-1:0]         sel,
    output logic                 multi
);
    logic [N-1:0] claim;
    logic [N-1:0] live;
    logic [CW-1:0] live_cnt;

    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign claim[g] = en[g] && (addr[g] == key);
        assign live[g]  = claim[g] && !kill[g];
    end

    always_comb begin
        sel      = '0;
        live_cnt = '0;
        for (int i = 0; i < N; i++) begin
            if (live[i]) begin
                sel      = '0;
                sel[i]   = 1'b1;
                live_cnt = live_cnt + 1'b1;
            end
        end
    end

    assign main_en = ~|claim;
    assign multi   = (live_cnt > 1);

    // R5: only enabled, unkilled spares may ever be selected
    p_live_only_r5: assert property (@(posedge clk) disable iff (!por_n)
        ((sel & ~(en & ~kill)) == '0));
    // R4: a selected spare always means the main line is cut
    p_main_cut_r4: assert property (@(posedge clk) disable iff (!por_n)
        (|sel) |-> !main_en);
endmodule

// File: rtl/spare_remap.sv
module spare_remap
    import spr_pkg::*;
#(
    parameter int QUADS    = 4,
    parameter int ROW_BITS = 6,
    parameter int COL_BITS = 8,
    parameter int SROWS    = 2,
    parameter int SCOLS    = 4,
    localparam int QW      = $clog2(QUADS),
    localparam int PAIRS   = QUADS / 2,
    localparam int N_RENT  = QUADS * SROWS,
    localparam int N_CENT  = PAIRS * SCOLS,
    localparam int RIW     = $clog2(N_RENT),
    localparam int CIW     = $clog2(N_CENT),
    localparam int PIW     = (RIW > CIW) ? RIW : CIW
) (
    input  logic                clk,
    input  logic                por_n,
    input  logic [QW-1:0]       acc_quad,
    input  logic [ROW_BITS-1:0] acc_row,
    input  logic [COL_BITS-1:0] acc_col,
    input  logic                prog_en,
    input  logic                prog_we,
    input  logic                prog_tgt,
    input  logic [PIW-1:0]      prog_idx,
    input  logic [FUSE_DW-1:0]  prog_data,
    output logic                row_main_en,
    output logic [SROWS-1:0]    row_spare_sel,
    output logic                col_main_en,
    output logic [SCOLS-1:0]    col_spare_sel,
    output logic                multi_hit
);
    logic wr_row, wr_col;
    logic [N_RENT-1:0][FUSE_DW-1:0] rfuse;
    logic [N_CENT-1:0][FUSE_DW-1:0] cfuse;

    spr_prog_ctrl u_ctrl (
        .clk(clk), .por_n(por_n), .prog_en(prog_en), .prog_we(prog_we),
        .prog_tgt(prog_tgt), .wr_row(wr_row), .wr_col(wr_col)
    );

    spr_fuse_bank #(.N_ENT(N_RENT), .DW(FUSE_DW)) u_rbank (
        .clk(clk), .por_n(por_n), .wr(wr_row), .idx(prog_idx[RIW-1:0]),
        .data(prog_data), .fuse_q(rfuse)
    );

    spr_fuse_bank #(.N_ENT(N_CENT), .DW(FUSE_DW)) u_cbank (
        .clk(clk), .por_n(por_n), .wr(wr_col), .idx(prog_idx[CIW-1:0]),
        .data(prog_data), .fuse_q(cfuse)
    );

    // Pick the entries that belong to the accessed quadrant / quadrant pair
    logic [SROWS-1:0]                r_en, r_kill;
    logic [SROWS-1:0][ROW_BITS-1:0]  r_addr;
    logic [SCOLS-1:0]                c_en, c_kill;
    logic [SCOLS-1:0][COL_BITS-1:0]  c_addr;
    logic                            r_multi, c_multi;
    logic [QW-1:0]                   pair_idx;

    assign pair_idx = acc_quad >> 1;

    for (genvar s = 0; s < SROWS; s++) begin : g_rsel
        logic [FUSE_DW-1:0] ent;
        assign ent       = rfuse[acc_quad * SROWS + s];
        assign r_en[s]   = ent[BIT_EN];
        assign r_kill[s] = ent[BIT_KILL];
        assign r_addr[s] = ent[ROW_BITS-1:0];
    end

    for (genvar s = 0; s < SCOLS; s++) begin : g_csel
        logic [FUSE_DW-1:0] ent;
        assign ent       = cfuse[pair_idx * SCOLS + s];
        assign c_en[s]   = ent[BIT_EN];
        assign c_kill[s] = ent[BIT_KILL];
        assign c_addr[s] = ent[COL_BITS-1:0];
    end

    spr_match #(.N(SROWS), .AW(ROW_BITS)) u_rmatch (
        .clk(clk), .por_n(por_n), .en(r_en), .kill(r_kill), .addr(r_addr),
        .key(acc_row), .main_en(row_main_en), .sel(row_spare_sel), .multi(r_multi)
    );

    spr_match #(.N(SCOLS), .AW(COL_BITS)) u_cmatch (
        .clk(clk), .por_n(por_n), .en(c_en), .kill(c_kill), .addr(c_addr),
        .key(acc_col), .main_en(col_main_en), .sel(col_spare_sel), .multi(c_multi)
    );

    assign multi_hit = r_multi || c_multi;

    // R5: at most one spare per group fires
    p_one_spare_r5: assert property (@(posedge clk) disable iff (!por_n)
        $onehot0(row_spare_sel) && $onehot0(col_spare_sel));
    // R6: a reported double match always leaves a spare selected
    p_multi_has_winner_r6: assert property (@(posedge clk) disable iff (!por_n)
        multi_hit |-> ((|row_spare_sel) || (|col_spare_sel)));
endmodule

// File: tb/spare_remap_tb.sv
`timescale 1ns/1ps
module spare_remap_tb_top;
    logic       clk = 1'b0;
    logic       por_n = 1'b0;
    logic [1:0] acc_quad = '0;
    logic [5:0] acc_row = '0;
    logic [7:0] acc_col = '0;
    logic       prog_en = 1'b0, prog_we = 1'b0, prog_tgt = 1'b0;
    logic [2:0] prog_idx = '0;
    logic [9:0] prog_data = '0;
    logic       row_main_en, col_main_en, multi_hit;
    logic [1:0] row_spare_sel;
    logic [3:0] col_spare_sel;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    spare_remap dut_i (
        .clk(clk), .por_n(por_n), .acc_quad(acc_quad), .acc_row(acc_row),
        .acc_col(acc_col), .prog_en(prog_en), .prog_we(prog_we),
        .prog_tgt(prog_tgt), .prog_idx(prog_idx), .prog_data(prog_data),
        .row_main_en(row_main_en), .row_spare_sel(row_spare_sel),
        .col_main_en(col_main_en), .col_spare_sel(col_spare_sel),
        .multi_hit(multi_hit)
    );

    // drive an access away from the edge, sample 1 ns later (combinational path)
    task automatic look(input string req, input logic [1:0] q, input logic [5:0] r,
                        input logic [7:0] c, input logic rm, input logic [1:0] rs,
                        input logic cm, input logic [3:0] cs, input logic mh);
        logic [8:0] act, exp;
        @(negedge clk);
        acc_quad = q; acc_row = r; acc_col = c;
        #1;
        act = {row_main_en, row_spare_sel, col_main_en, col_spare_sel, multi_hit};
        exp = {rm, rs, cm, cs, mh};
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s q=%0d r=%0d c=%0d act=%b exp=%b", req, q, r, c, act, exp);
        end
    endtask

    task automatic open_win();
        @(negedge clk); prog_en = 1'b1;
        @(negedge clk);
    endtask

    task automatic close_win();
        @(negedge clk); prog_en = 1'b0; prog_we = 1'b0;
    endtask

    task automatic put(input logic tgt, input logic [2:0] idx, input logic [9:0] d);
        @(negedge clk);
        prog_we = 1'b1; prog_tgt = tgt; prog_idx = idx; prog_data = d;
        @(negedge clk);
        prog_we = 1'b0;
    endtask

    task automatic t_reset();
        look("R1 blank", 2'd0, 6'd5, 8'd7, 1, 2'b00, 1, 4'b0000, 0);
        look("R1 blank", 2'd3, 6'd63, 8'd255, 1, 2'b00, 1, 4'b0000, 0);
    endtask

    task automatic t_row();
        open_win(); put(1'b0, 3'd2, {2'b10, 8'd9}); close_win();
        look("R2 hit", 2'd1, 6'd9, 8'd0, 0, 2'b01, 1, 4'b0000, 0);
        look("R2 other quad", 2'd0, 6'd9, 8'd0, 1, 2'b00, 1, 4'b0000, 0);
        look("R2 other row", 2'd1, 6'd10, 8'd0, 1, 2'b00, 1, 4'b0000, 0);
    endtask

    task automatic t_col();
        open_win(); put(1'b1, 3'd6, {2'b10, 8'd200}); close_win();
        look("R3 pair q2", 2'd2, 6'd0, 8'd200, 1, 2'b00, 0, 4'b0100, 0);
        look("R3 pair q3", 2'd3, 6'd0, 8'd200, 1, 2'b00, 0, 4'b0100, 0);
        look("R3 other pair", 2'd0, 6'd0, 8'd200, 1, 2'b00, 1, 4'b0000, 0);
    endtask

    task automatic t_chain();
        open_win(); put(1'b0, 3'd2, {2'b01, 8'd0}); close_win();
        look("R4 killed keeps main cut", 2'd1, 6'd9, 8'd0, 0, 2'b00, 1, 4'b0000, 0);
        open_win(); put(1'b0, 3'd3, {2'b10, 8'd9}); close_win();
        look("R5 later spare takes over", 2'd1, 6'd9, 8'd0, 0, 2'b10, 1, 4'b0000, 0);
    endtask

    task automatic t_multi();
        open_win();
        put(1'b1, 3'd0, {2'b10, 8'd50});
        put(1'b1, 3'd3, {2'b10, 8'd50});
        close_win();
        look("R5 R6 highest wins, flag", 2'd0, 6'd1, 8'd50, 1, 2'b00, 0, 4'b1000, 1);
        look("R6 no flag single", 2'd2, 6'd1, 8'd200, 1, 2'b00, 0, 4'b0100, 0);
    endtask

    task automatic t_one_way();
        open_win();
        put(1'b0, 3'd1, {2'b10, 8'd3});
        put(1'b0, 3'd1, {2'b10, 8'd4});
        close_win();
        look("R8 old address gone", 2'd0, 6'd3, 8'd0, 1, 2'b00, 1, 4'b0000, 0);
        look("R8 ORed address", 2'd0, 6'd7, 8'd0, 0, 2'b10, 1, 4'b0000, 0);
    endtask

    task automatic t_window();
        put(1'b0, 3'd6, {2'b10, 8'd20});
        look("R7 locked write ignored", 2'd3, 6'd20, 8'd0, 1, 2'b00, 1, 4'b0000, 0);
        @(negedge clk);
        prog_en = 1'b1; prog_we = 1'b1; prog_tgt = 1'b0; prog_idx = 3'd6;
        prog_data = {2'b10, 8'd20};
        @(negedge clk); prog_we = 1'b0;
        close_win();
        look("R7 first cycle write ignored", 2'd3, 6'd20, 8'd0, 1, 2'b00, 1, 4'b0000, 0);
        open_win(); put(1'b0, 3'd6, {2'b10, 8'd20}); close_win();
        look("R7 open write accepted", 2'd3, 6'd20, 8'd0, 0, 2'b01, 1, 4'b0000, 0);
    endtask

    task automatic t_same_cycle();
        // R9: address changes mid-cycle; sample 1 ns later with no edge between
        @(negedge clk);
        acc_quad = 2'd1; acc_row = 6'd9; acc_col = 8'd0;
        #0.5;
        acc_row = 6'd11;
        #0.5;
        n_chk++;
        if (row_main_en !== 1'b1 || row_spare_sel !== 2'b00) begin
            n_err++;
            $display("FAIL R9 act=%b%b exp=100", row_main_en, row_spare_sel);
        end
        acc_row = 6'd9;
        #0.5;
        n_chk++;
        if (row_main_en !== 1'b0 || row_spare_sel !== 2'b10) begin
            n_err++;
            $display("FAIL R9 act=%b%b exp=010", row_main_en, row_spare_sel);
        end
    endtask

    task automatic t_por();
        @(negedge clk); por_n = 1'b0;
        @(negedge clk); por_n = 1'b1;
        look("R1 por clears", 2'd1, 6'd9, 8'd50, 1, 2'b00, 1, 4'b0000, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        por_n = 1'b1;
        t_reset();
        t_row();
        t_col();
        t_chain();
        t_multi();
        t_one_way();
        t_window();
        t_same_cycle();
        t_por();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog act=running exp=done");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule